// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

A memory-mapped supervision timer with one 16-bit control register and a free-running counter. The counter advances on one of two clock-enable strobes, fast or slow. It stops after a chosen number of ticks, picked from four. In watchdog mode that expiry raises a one-cycle system reset request. In interval mode it instead sets a sticky flag. The flag becomes an interrupt when the enable input allows it, and the counter keeps running, so firmware gets a steady periodic event.

A write counts only if its upper byte carries the key 0x5A. Any other write is dropped and treated as a fault, so it raises a reset request. A self-clearing control bit restarts the count, and a hold bit freezes it.

Top module: `guard_timer`

## Requirements
- R1: A write is accepted only when `wr_data[15:8]` is 0x5A. A write with any other upper byte leaves the control bits unchanged and makes `rst_req` high in the cycle after the write.
- R2: `rd_data` is 0x69 in bits 15:8. Bits 7:0 show the stored control bits at positions 7, 4, 2, 1 and 0. Bits 6, 5 and 3 always read 0.
- R3: After reset the control bits are zero, so the block is in watchdog mode on the fast strobe with the 32768 tap, not held. `rst_req`, `flag` and `irq` are low.
- R4: Control bits 1:0 select the expiry after 32768 (00), 8192 (01), 512 (10) or 64 (11) ticks of the selected strobe, counted from a restart.
- R5: Control bit 2 selects the strobe: 0 counts `tick_fast`, 1 counts `tick_slow`. The other strobe has no effect.
- R6: An accepted write with bit 3 set zeroes the counter in that cycle. It takes precedence over a tick in the same cycle. The bit is not stored.
- R7: While control bit 7 is 1 the counter does not advance and no expiry occurs.
- R8: With control bit 4 at 0 (watchdog), an expiry drives `rst_req` high for exactly one cycle and leaves `flag` unchanged.
- R9: With control bit 4 at 1 (interval), an expiry sets `flag`. The counter wraps to zero and keeps counting, so expiries repeat once per period.
- R10: `flag` stays set until `flag_clr` or `irq_ack` is high. A new expiry in the same cycle as a clear leaves it set. `irq` is `flag` gated by `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Write data: key in 15:8, control bits in 7:0 |
| rd_data | output | 16 | Read data: 0x69 and control bits |
| tick_fast | input | 1 | Fast clock-enable strobe |
| tick_slow | input | 1 | Slow clock-enable strobe |
| irq_en | input | 1 | Interval interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| flag_clr | input | 1 | Software clear of the flag |
| flag | output | 1 | Interval flag |
| irq | output | 1 | Interval interrupt |
| rst_req | output | 1 | System reset request pulse |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a flag clear and a new interval expiry. The bench provokes it by driving `flag_clr` together with the final tick of a period, and it expects `flag` to stay set. The second pair is a counter-clear write and a tick. The bench drives the clearing write in the same cycle as a slow tick, then checks that a full 64 more ticks are needed before the flag rises.

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int TAP0 = 32768,
  parameter int TAP1 = 8192,
  parameter int TAP2 = 512,
  parameter int TAP3 = 64,
  parameter logic [7:0] WR_KEY = 8'h5A,
  parameter logic [7:0] RD_KEY = 8'h69
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        tick_fast,
  input  logic        tick_slow,
  input  logic        irq_en,
  input  logic        irq_ack,
  input  logic        flag_clr,
  output logic        flag,
  output logic        irq,
  output logic        rst_req
);
  localparam int CNT_W = $clog2(TAP0);
  localparam logic [7:0] CTRL_MASK = 8'h97;

  logic [7:0]       ctrl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   lim;
  logic key_ok, bad_wr, clr_now, tick_sel, run, expire;

  assign key_ok   = wr_en && (wr_data[15:8] == WR_KEY);
  assign bad_wr   = wr_en && (wr_data[15:8] != WR_KEY);
  assign clr_now  = key_ok && wr_data[3];
  assign tick_sel = ctrl[2] ? tick_slow : tick_fast;
  assign run      = tick_sel && !ctrl[7];

  always_comb begin
    case (ctrl[1:0])
      2'b00:   lim = (CNT_W+1)'(TAP0);
      2'b01:   lim = (CNT_W+1)'(TAP1);
      2'b10:   lim = (CNT_W+1)'(TAP2);
      default: lim = (CNT_W+1)'(TAP3);
    endcase
  end

  assign expire  = run && !clr_now && ({1'b0, cnt} >= lim - 1'b1);
  assign rd_data = {RD_KEY, ctrl};
  assign irq     = flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      cnt     <= '0;
      flag    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= bad_wr || (expire && !ctrl[4]);
      if (key_ok) ctrl <= wr_data[7:0] & CTRL_MASK;
      if (clr_now)     cnt <= '0;
      else if (expire) cnt <= '0;
      else if (run)    cnt <= cnt + 1'b1;
      if (expire && ctrl[4])        flag <= 1'b1;
      else if (flag_clr || irq_ack) flag <= 1'b0;
    end
  end

  AST_BADKEY_RESET: assert property (@(posedge clk) disable iff (!rst_n) bad_wr |=> rst_req); // R1
  AST_BADKEY_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (bad_wr && !key_ok) |=> $stable(rd_data)); // R1
  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n) clr_now |=> (cnt == '0)); // R6
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (ctrl[7] && !wr_en) |=> $stable(cnt)); // R7
  AST_WDOG_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n) (!ctrl[4] && !flag) |=> !flag); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag && !flag_clr && !irq_ack) |=> flag); // R10
endmodule

// File: tb/test_guard_timer.sv
module test_guard_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, tick_fast = 1'b0, tick_slow = 1'b0;
  logic irq_en = 1'b0, irq_ack = 1'b0, flag_clr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic flag, irq, rst_req;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  guard_timer i_guard_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .irq_en(irq_en), .irq_ack(irq_ack),
    .flag_clr(flag_clr), .flag(flag), .irq(irq), .rst_req(rst_req)
  );

  // {write data, expected read data, expected rst_req}
  localparam logic [32:0] VEC [8] = '{
    {16'h5A00, 16'h6900, 1'b0},
    {16'h5A08, 16'h6900, 1'b0},
    {16'h5A97, 16'h6997, 1'b0},
    {16'h5AFF, 16'h6997, 1'b0},
    {16'hA5FF, 16'h6997, 1'b1},
    {16'h5A60, 16'h6900, 1'b0},
    {16'h5B10, 16'h6900, 1'b1},
    {16'h5A12, 16'h6912, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n, input bit slow);
    if (n > 0) begin
      @(negedge clk);
      if (slow) tick_slow = 1'b1; else tick_fast = 1'b1;
      repeat (n - 1) @(negedge clk);
      @(negedge clk);
      tick_fast = 1'b0; tick_slow = 1'b0;
    end
  endtask

  task automatic clr_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 ctrl", rd_data, 16'h6900);
    chk("R3 outs", {13'd0, rst_req, flag, irq}, 16'h0000);
    rst_n = 1'b1;

    for (int k = 0; k < 8; k++) begin
      wr(VEC[k][32:17]);
      chk("R1/R2 read", rd_data, VEC[k][16:1]);
      chk("R1 rst_req", {15'd0, rst_req}, {15'd0, VEC[k][0]});
    end

    // interval mode, tap 64, fast
    wr(16'h5A1B);
    chk("R2 clear bit reads 0", rd_data, 16'h6913);
    ticks(63, 0);
    chk("R9 no flag before 64", {15'd0, flag}, 16'd0);
    ticks(1, 0);
    chk("R9 flag at 64", {15'd0, flag}, 16'd1);
    chk("R10 irq gated off", {15'd0, irq}, 16'd0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R10 irq enabled", {15'd0, irq}, 16'd1);
    ticks(64, 0);
    chk("R10 flag sticky", {15'd0, flag}, 16'd1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R10 ack clears", {15'd0, flag}, 16'd0);
    ticks(63, 0);
    chk("R9 continues no early flag", {15'd0, flag}, 16'd0);
    ticks(1, 0);
    chk("R9 repeat expiry", {15'd0, flag}, 16'd1);
    clr_flag();
    ticks(63, 0);
    @(negedge clk); tick_fast = 1'b1; flag_clr = 1'b1;
    @(negedge clk); tick_fast = 1'b0; flag_clr = 1'b0;
    chk("R10 set wins over clear", {15'd0, flag}, 16'd1);
    clr_flag();

    // hold
    wr(16'h5A9B);
    ticks(100, 0);
    chk("R7 held no expiry", {15'd0, flag}, 16'd0);
    wr(16'h5A13);
    ticks(63, 0);
    chk("R7 count frozen", {15'd0, flag}, 16'd0);
    ticks(1, 0);
    chk("R7 resumes", {15'd0, flag}, 16'd1);
    clr_flag();

    // slow clock select
    wr(16'h5A1F);
    ticks(200, 0);
    chk("R5 fast ignored", {15'd0, flag}, 16'd0);
    ticks(64, 1);
    chk("R5 slow counts", {15'd0, flag}, 16'd1);
    clr_flag();

    // clear collides with tick
    wr(16'h5A17);
    ticks(40, 1);
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h5A1F; tick_slow = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick_slow = 1'b0;
    ticks(63, 1);
    chk("R6 restart over tick", {15'd0, flag}, 16'd0);
    ticks(1, 1);
    chk("R6 full period after clear", {15'd0, flag}, 16'd1);
    clr_flag();

    // watchdog mode taps
    wr(16'h5A0B);
    ticks(63, 0);
    chk("R8 no early reset", {15'd0, rst_req}, 16'd0);
    ticks(1, 0);
    chk("R8 reset at 64", {15'd0, rst_req}, 16'd1);
    chk("R8 flag untouched", {15'd0, flag}, 16'd0);
    @(negedge clk);
    chk("R8 one-cycle pulse", {15'd0, rst_req}, 16'd0);
    wr(16'h5A0A);
    ticks(511, 0);
    chk("R4 tap 512 early", {15'd0, rst_req}, 16'd0);
    ticks(1, 0);
    chk("R4 tap 512", {15'd0, rst_req}, 16'd1);
    wr(16'h5A09);
    ticks(8191, 0);
    chk("R4 tap 8192 early", {15'd0, rst_req}, 16'd0);
    ticks(1, 0);
    chk("R4 tap 8192", {15'd0, rst_req}, 16'd1);
    wr(16'h5A08);
    ticks(32767, 0);
    chk("R4 tap 32768 early", {15'd0, rst_req}, 16'd0);
    ticks(1, 0);
    chk("R4 tap 32768", {15'd0, rst_req}, 16'd1);

    // bad key mid-operation
    wr(16'h0012);
    chk("R1 bad key reset", {15'd0, rst_req}, 16'd1);
    chk("R1 bad key ignored", rd_data, 16'h6900);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule